// File: doc/BRIEF.md
# Shortened-Cycle LFSR Counter

This block is a free-running counter made from a shift register with linear feedback. Its period is a chosen modulus N, which may be any value up to the maximal-length period 2^W-1 of a W-bit register. The register starts at a seed value. It steps through the pseudo-random sequence that its feedback taps define. When it reaches the N-th state counted from the seed, the next step loads the seed again instead of shifting. The block emits a one-cycle wrap pulse when that reload happens.

A direct compare against the terminal state would add a wide AND gate to the reload path. Instead, a state K counts ahead of the terminal one is matched. That match result then passes through K registers, so the reload control comes straight from a flop. The early state and the terminal state are computed at elaboration by stepping the sequence from the seed. The enable input freezes the whole block, so the period counts enabled cycles only. A typical use is a compact divide-by-N tick generator, where a binary counter with a wide carry chain would cost too much.

Top module: `lfsr_mod_counter`

## Requirements
- R1: While reset is high at a rising clock edge, the register becomes SEED (default 1) and the detector pipeline is cleared. The wrap output is low during reset and in the first cycle after it, even when enable is high.
- R2: On each enabled edge where no reload is due, the register shifts left by one bit. The new bit 0 is the XOR of the register bits whose positions are set in TAPS. The default TAPS is 9'h110 (bit positions 8 and 4), which gives a maximal-length sequence for W=9.
- R3: With enable high on every cycle, wrap is high for exactly one cycle in every N. That cycle is the one in which the register holds the N-th state counted from the seed (the seed is the first). The edge that closes that cycle loads SEED.
- R4: While enable is low, the register and the detector pipeline keep their values and wrap stays low. Disabled cycles therefore do not count toward the period, including a stall while the terminal state is held.
- R5: Within one period, no register value appears twice, and the register never holds zero.
- R6: A reset that arrives while the detector is armed, at the terminal state or one state before it, causes no early reload. The next period after reset is a full N enabled cycles.
- R7: The detector depth K is a parameter (default 1). For every legal K from 1 to N-1, the reload lands on the same terminal state, because the match point moves K states earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the block |
| state | output | W | Current register value |
| wrap | output | 1 | High in the cycle whose closing edge reloads the seed |

## Verification
A behavioural model steps the sequence and predicts the state and wrap output for every cycle. A scoreboard checks the model against the outputs. Enable is driven in four ways: held high for several periods, which shows the exact period and the shift rule; alternating; irregular; and dropped for several cycles while the terminal state is held. Together these show whether the detector pipeline advances only with enable or drifts against the register. Resets are applied at the terminal state and one state before it, which would expose a pipeline bit that survives reset. A second instance with a deeper detector, a different width and a shorter modulus checks that the early-match point moves with K.

// File: rtl/lfsr_mod_counter.sv
module lfsr_mod_counter #(
  parameter int W = 9,
  parameter int N = 257,
  parameter int K = 1,
  parameter logic [W-1:0] TAPS = 'h110,
  parameter logic [W-1:0] SEED = 'd1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] state,
  output logic         wrap
);

  function automatic logic [W-1:0] adv(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] walk(input int n);
    logic [W-1:0] s;
    s = SEED;
    for (int i = 0; i < n; i++) s = adv(s);
    return s;
  endfunction

  localparam logic [W-1:0] EARLY = walk(N - 1 - K);
  localparam logic [W-1:0] TERM  = walk(N - 1);
  localparam int CW = $clog2(N + 1);

  logic [W-1:0] q;
  logic [K-1:0] det;
  logic         hit;

  assign hit   = (q == EARLY);
  assign state = q;
  assign wrap  = en & det[K-1];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else if (en) q <= det[K-1] ? SEED : adv(q);
  end

  generate
    if (K == 1) begin : g_det1
      always_ff @(posedge clk) begin
        if (rst) det <= '0;
        else if (en) det <= hit;
      end
    end else begin : g_detn
      always_ff @(posedge clk) begin
        if (rst) det <= '0;
        else if (en) det <= {det[K-2:0], hit};
      end
    end
  endgenerate

  logic [CW-1:0] span;
  always_ff @(posedge clk) begin
    if (rst) span <= '0;
    else if (en) span <= wrap ? '0 : span + 1'b1;
  end

  p_reset_seed_r1: assert property (@(posedge clk) $fell(rst) |-> (q == SEED && !det[K-1]));
  p_load_seed_r3: assert property (@(posedge clk) disable iff (rst) wrap |=> q == SEED);
  p_wrap_term_r7: assert property (@(posedge clk) disable iff (rst) wrap |-> q == TERM);
  p_period_r3: assert property (@(posedge clk) disable iff (rst) wrap |-> span == CW'(N - 1));
  p_span_bound_r6: assert property (@(posedge clk) disable iff (rst) span < CW'(N));
  p_hold_r4: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q) && $stable(det));
  p_nonzero_r5: assert property (@(posedge clk) disable iff (rst) q != '0);

endmodule

// File: tb/lfsr_mod_counter_tb.sv
module lfsr_mod_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int N = 257;
  localparam logic [W-1:0] TAPS = 9'h110;
  localparam logic [W-1:0] SEED = 9'd1;
  localparam int N2 = 20;

  typedef struct {
    logic [W-1:0] q;
    logic         wrap;
    string        tag;
  } item_t;

  logic clk = 0, rst = 1, en = 0;
  logic [W-1:0] state;
  logic wrap;
  logic [4:0] state2;
  logic wrap2;

  int checks = 0, fails = 0;
  item_t sb[$];

  lfsr_mod_counter #(.W(W), .N(N), .K(1), .TAPS(TAPS), .SEED(SEED)) u_dut (
    .clk(clk), .rst(rst), .en(en), .state(state), .wrap(wrap));

  lfsr_mod_counter #(.W(5), .N(N2), .K(3), .TAPS(5'h14), .SEED(5'd1)) u_dut2 (
    .clk(clk), .rst(rst), .en(en), .state(state2), .wrap(wrap2));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] mq = SEED;
  int midx = 0;

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  task automatic step(input logic e, input string tag);
    item_t it;
    @(negedge clk); #1;
    en = e;
    it.q = mq; it.wrap = e && (midx == N - 1); it.tag = tag;
    sb.push_back(it);
    if (e) begin
      if (midx == N - 1) begin mq = SEED; midx = 0; end
      else begin mq = nxt(mq); midx++; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst = 1; en = 1;
    @(negedge clk); #1;
    checks++;
    if (state !== SEED || wrap !== 1'b0 || wrap2 !== 1'b0) begin
      fails++;
      $display("FAIL R1: state=%h wrap=%b wrap2=%b expected state=%h wrap=0", state, wrap, wrap2, SEED);
    end
    @(negedge clk); #1;
    rst = 0; en = 0;
    mq = SEED; midx = 0;
  endtask

  logic [2**W-1:0] seen = '0;
  logic fresh = 1;
  int per = 0, per2 = 0;

  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst) begin
        seen = '0; fresh = 1; per = 0; per2 = 0;
      end else begin
        if (sb.size() > 0) begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (state !== it.q || wrap !== it.wrap) begin
            fails++;
            $display("FAIL %s: state=%h wrap=%b expected state=%h wrap=%b", it.tag, state, wrap, it.q, it.wrap);
          end
        end
        if (fresh) begin
          checks++;
          if (state == '0 || seen[state]) begin
            fails++;
            $display("FAIL R5: state=%h repeated or zero, expected a new nonzero state", state);
          end
          seen[state] = 1'b1;
        end
        fresh = en;
        if (en) begin
          if (wrap) begin
            checks++;
            if (per != N - 1) begin
              fails++;
              $display("FAIL R3: wrap after %0d steps, expected %0d", per, N - 1);
            end
            per = 0; seen = '0;
          end else per++;
          if (wrap2) begin
            checks++;
            if (per2 != N2 - 1) begin
              fails++;
              $display("FAIL R7: deep-detector wrap after %0d steps, expected %0d", per2, N2 - 1);
            end
            per2 = 0;
          end else per2++;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 3 * N; i++) step(1'b1, "R2");
    for (int i = 0; i < 2 * N; i++) step(i % 2 == 0, "R4");
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, "R4");
    while (midx != N - 1) step(1'b1, "R3");
    for (int i = 0; i < 6; i++) step(1'b0, "R4");
    step(1'b1, "R3");
    while (midx != N - 1) step(1'b1, "R3");
    do_reset();
    for (int i = 0; i < N + 5; i++) step(1'b1, "R6");
    while (midx != N - 2) step(1'b1, "R6");
    do_reset();
    for (int i = 0; i < N + 5; i++) step(1'b1, "R6");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule